// File: doc/BRIEF.md
# Top-Three Priority Candidate Sorter

The block takes one bunch slot of track-segment candidates per clock from eighteen parallel input channels. The channels are organised as nine sources with two candidates each, and each candidate is carried as two 16-bit frames. From each slot the block picks the three best eligible candidates. It places them by rank on three output slots, each slot with its own valid. It returns a winner bit to every input channel and lights one indicator per occupied output slot.

A candidate is eligible only when its flag bit is set and its quality field is nonzero. Higher quality ranks better. When two qualities are equal, the higher channel index wins. The selection is pipelined: a slot is accepted on every clock in which the strobe is high, and its results appear a fixed two clocks later. Channel count, candidates per source, frame width, field positions, number of output slots and the tie direction are all parameters.

Top module: `trk_top3_sorter`

## Requirements
- R1: A candidate is eligible only when frame 1 bit 15 (the flag) is 1 and frame 1 bits [14:11] (quality) are nonzero. An ineligible candidate never appears on an output and never gets a winner bit.
- R2: Output slot 0 carries the eligible candidate of highest quality, slot 1 the second and slot 2 the third.
- R3: Channel c = 2*source + candidate occupies in_frames[32c+31:32c]. Among eligible candidates of equal quality, the higher channel index takes the better rank.
- R4: With n eligible candidates, out_valid holds min(n,3) ones, filled from slot 0 upward (1 → 3'b001, 2 → 3'b011, 3 or more → 3'b111).
- R5: An output slot without a selected candidate drives all-zero frames with its valid low.
- R6: led[k] is 1 exactly when output slot k holds a selected candidate.
- R7: winner[c] is 1 exactly when channel c was placed in one of the three output slots.
- R8: A slot strobed at clock edge t produces its outputs after edge t+1. One slot is accepted every cycle. A cycle without a strobe, or a slot with all-zero data, gives empty outputs and has no effect on the results of other slots.
- R9: While reset is asserted, all outputs, winner bits and indicators are zero.
- R10: A selected candidate's 32 bits pass unchanged, with frame 1 in bits [15:0] and frame 2 in bits [31:16] of the output slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | Marks in_frames as a slot to sort |
| in_frames | input | 576 | 18 candidates of 32 bits each, channel c at [32c+31:32c] |
| out_frames | output | 96 | Three ranked output slots of 32 bits, slot k at [32k+31:32k] |
| out_valid | output | 3 | Per-slot valid |
| winner | output | 18 | Per-channel winner bit |
| led | output | 3 | Per-slot occupancy indicator |

## Verification
The hardest situation to reach is a wide tie, where many channels share one quality and rank must come only from channel index. A random slot rarely has more than three eligible equals. The stimulus therefore includes a slot with all eighteen channels at one quality, and random slots whose quality is drawn from only a few small values so that ties at the rank boundary happen often. Ineligible candidates carrying high quality and all-zero slots placed between live slots check that such candidates do not block selection in either slot.

// File: rtl/trk_sort_pkg.sv
package trk_sort_pkg;
   typedef enum logic {
      TIE_HIGH_INDEX = 1'b0,
      TIE_LOW_INDEX  = 1'b1
   } tie_mode_e;
endpackage

// File: rtl/trk_cand_extract.sv
module trk_cand_extract #(
   parameter int FRAME_W  = 16,
   parameter int QUAL_W   = 4,
   parameter int QUAL_LSB = 11,
   parameter int FLAG_BIT = 15,
   localparam int CAND_W  = 2 * FRAME_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  logic [CAND_W-1:0] cand_i,
   output logic              elig_o,
   output logic [QUAL_W-1:0] qual_o,
   output logic [CAND_W-1:0] cand_o
);
   logic [QUAL_W-1:0] qual_raw;
   logic              elig_raw;

   assign qual_raw = cand_i[QUAL_LSB +: QUAL_W];
   assign elig_raw = strobe_i & cand_i[FLAG_BIT] & (|qual_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elig_o <= 1'b0;
         qual_o <= '0;
         cand_o <= '0;
      end else begin
         elig_o <= elig_raw;
         qual_o <= elig_raw ? qual_raw : '0;
         cand_o <= elig_raw ? cand_i : '0;
      end
   end
endmodule

// File: rtl/trk_rank_select.sv
module trk_rank_select
   import trk_sort_pkg::*;
#(
   parameter int        NUM_CH   = 18,
   parameter int        NUM_OUT  = 3,
   parameter int        QUAL_W   = 4,
   parameter int        CAND_W   = 32,
   parameter tie_mode_e TIE_MODE = TIE_HIGH_INDEX,
   localparam int       RANK_W   = $clog2(NUM_CH + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         elig_i,
   input  logic [NUM_CH*QUAL_W-1:0]  qual_i,
   input  logic [NUM_CH*CAND_W-1:0]  cand_i,
   output logic [NUM_OUT*CAND_W-1:0] out_frames_o,
   output logic [NUM_OUT-1:0]        out_valid_o,
   output logic [NUM_CH-1:0]         winner_o,
   output logic [NUM_OUT-1:0]        led_o
);
   logic [NUM_CH-1:0]  beaten_by [NUM_CH];
   logic [RANK_W-1:0]  rank      [NUM_CH];
   logic [NUM_CH-1:0]  picked;
   logic [NUM_OUT*CAND_W-1:0] slot_d;
   logic [NUM_OUT-1:0]        slot_v;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_row
      for (genvar j = 0; j < NUM_CH; j++) begin : g_col
         if (i == j) begin : g_self
            assign beaten_by[i][j] = 1'b0;
         end else begin : g_other
            logic tie_wins;
            if (TIE_MODE == TIE_HIGH_INDEX) begin : g_hi
               assign tie_wins = (j > i);
            end else begin : g_lo
               assign tie_wins = (j < i);
            end
            assign beaten_by[i][j] = elig_i[j] &
               ((qual_i[j*QUAL_W +: QUAL_W] > qual_i[i*QUAL_W +: QUAL_W]) |
                ((qual_i[j*QUAL_W +: QUAL_W] == qual_i[i*QUAL_W +: QUAL_W]) & tie_wins));
         end
      end
      assign rank[i]   = RANK_W'($countones(beaten_by[i]));
      assign picked[i] = elig_i[i] & (rank[i] < RANK_W'(NUM_OUT));
   end

   always_comb begin
      slot_d = '0;
      slot_v = '0;
      for (int k = 0; k < NUM_OUT; k++) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (picked[i] && (rank[i] == RANK_W'(k))) begin
               slot_d[k*CAND_W +: CAND_W] = slot_d[k*CAND_W +: CAND_W] | cand_i[i*CAND_W +: CAND_W];
               slot_v[k] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_frames_o <= '0;
         out_valid_o  <= '0;
         winner_o     <= '0;
         led_o        <= '0;
      end else begin
         out_frames_o <= slot_d;
         out_valid_o  <= slot_v;
         winner_o     <= picked;
         led_o        <= slot_v;
      end
   end
endmodule

// File: rtl/trk_top3_sorter.sv
module trk_top3_sorter
   import trk_sort_pkg::*;
#(
   parameter int        NUM_SRC      = 9,
   parameter int        CAND_PER_SRC = 2,
   parameter int        FRAME_W      = 16,
   parameter int        QUAL_W       = 4,
   parameter int        QUAL_LSB     = 11,
   parameter int        FLAG_BIT     = 15,
   parameter int        NUM_OUT      = 3,
   parameter tie_mode_e TIE_MODE     = TIE_HIGH_INDEX,
   localparam int       NUM_CH       = NUM_SRC * CAND_PER_SRC,
   localparam int       CAND_W       = 2 * FRAME_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_strobe,
   input  logic [NUM_CH*CAND_W-1:0]  in_frames,
   output logic [NUM_OUT*CAND_W-1:0] out_frames,
   output logic [NUM_OUT-1:0]        out_valid,
   output logic [NUM_CH-1:0]         winner,
   output logic [NUM_OUT-1:0]        led
);
   if (FLAG_BIT >= FRAME_W || QUAL_LSB + QUAL_W > FRAME_W) begin : g_bad_field
      $error("flag or quality field outside frame 1");
   end
   if (FLAG_BIT >= QUAL_LSB && FLAG_BIT < QUAL_LSB + QUAL_W) begin : g_bad_overlap
      $error("flag bit overlaps quality field");
   end
   if (NUM_OUT < 1 || NUM_OUT > NUM_CH) begin : g_bad_out
      $error("output slot count must be within 1..channel count");
   end

   logic [NUM_CH-1:0]        elig_q;
   logic [NUM_CH*QUAL_W-1:0] qual_q;
   logic [NUM_CH*CAND_W-1:0] cand_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      trk_cand_extract #(
         .FRAME_W (FRAME_W),
         .QUAL_W  (QUAL_W),
         .QUAL_LSB(QUAL_LSB),
         .FLAG_BIT(FLAG_BIT)
      ) u_extract (
         .clk     (clk),
         .rst_n   (rst_n),
         .strobe_i(in_strobe),
         .cand_i  (in_frames[c*CAND_W +: CAND_W]),
         .elig_o  (elig_q[c]),
         .qual_o  (qual_q[c*QUAL_W +: QUAL_W]),
         .cand_o  (cand_q[c*CAND_W +: CAND_W])
      );
   end

   trk_rank_select #(
      .NUM_CH  (NUM_CH),
      .NUM_OUT (NUM_OUT),
      .QUAL_W  (QUAL_W),
      .CAND_W  (CAND_W),
      .TIE_MODE(TIE_MODE)
   ) u_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .elig_i      (elig_q),
      .qual_i      (qual_q),
      .cand_i      (cand_q),
      .out_frames_o(out_frames),
      .out_valid_o (out_valid),
      .winner_o    (winner),
      .led_o       (led)
   );
endmodule

// File: rtl/trk_top3_sorter_chk.sv
module trk_top3_sorter_chk #(
   parameter int NUM_CH   = 18,
   parameter int NUM_OUT  = 3,
   parameter int FRAME_W  = 16,
   parameter int QUAL_W   = 4,
   parameter int QUAL_LSB = 11,
   parameter int FLAG_BIT = 15,
   localparam int CAND_W  = 2 * FRAME_W
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_strobe,
   input logic [NUM_OUT*CAND_W-1:0] out_frames,
   input logic [NUM_OUT-1:0]        out_valid,
   input logic [NUM_CH-1:0]         winner,
   input logic [NUM_OUT-1:0]        led
);
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
      // R1: an occupied slot holds an eligible candidate
      a_r1_slot_eligible: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[k] |-> (out_frames[k*CAND_W + FLAG_BIT] &&
                           out_frames[k*CAND_W + QUAL_LSB +: QUAL_W] != '0));
      // R5: an empty slot drives zeros
      a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[k] |-> (out_frames[k*CAND_W +: CAND_W] == '0));
      // R6: a lit indicator means the slot carries a flagged candidate
      a_r6_led_occupied: assert property (@(posedge clk) disable iff (!rst_n)
         led[k] |-> out_frames[k*CAND_W + FLAG_BIT]);
      if (k > 0) begin : g_pair
         // R2: rank order by quality
         a_r2_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> (out_frames[(k-1)*CAND_W + QUAL_LSB +: QUAL_W] >=
                              out_frames[k*CAND_W + QUAL_LSB +: QUAL_W]));
         // R4: slots fill from slot 0 upward
         a_r4_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> out_valid[k-1]);
      end
   end

   // R7: one winner bit per occupied slot
   a_r7_winner_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(winner) == $countones(out_valid));

   // R8: nothing emerges two cycles after an unstrobed cycle
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_strobe, 2) |-> (out_valid == '0 && winner == '0));

   // R9: reset holds every output at zero
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_r9_reset_clear: assert (out_valid == '0 && winner == '0 && led == '0 && out_frames == '0);
      end
   end
endmodule

bind trk_top3_sorter trk_top3_sorter_chk #(
   .NUM_CH  (NUM_CH),
   .NUM_OUT (NUM_OUT),
   .FRAME_W (FRAME_W),
   .QUAL_W  (QUAL_W),
   .QUAL_LSB(QUAL_LSB),
   .FLAG_BIT(FLAG_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_strobe (in_strobe),
   .out_frames(out_frames),
   .out_valid (out_valid),
   .winner    (winner),
   .led       (led)
);

// File: tb/tb_trk_top3_sorter.sv
`timescale 1ns/1ps
module tb_trk_top3_sorter;
   localparam int NCH = 18;
   localparam int NOUT = 3;
   localparam int CW = 32;

   typedef struct packed {
      logic [NOUT*CW-1:0] fr;
      logic [NOUT-1:0]    v;
      logic [NCH-1:0]     w;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_strobe = 1'b0;
   logic [NCH*CW-1:0]  in_frames = '0;
   logic [NOUT*CW-1:0] out_frames;
   logic [NOUT-1:0]    out_valid;
   logic [NCH-1:0]     winner;
   logic [NOUT-1:0]    led;

   int   checks = 0;
   int   failures = 0;
   bit   cmp_en = 1'b0;
   exp_t hist[$];

   always #2 clk = ~clk;

   trk_top3_sorter dut (
      .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .in_frames(in_frames),
      .out_frames(out_frames), .out_valid(out_valid), .winner(winner), .led(led)
   );

   function automatic logic [CW-1:0] mk(int q, bit flag, int pay);
      logic [15:0] f1, f2;
      f1 = {flag, 4'(q), 11'(pay)};
      f2 = 16'(pay * 7 + 16'h5a3c);
      return {f2, f1};
   endfunction

   // Behavioural reference: repeated pick of the best remaining candidate
   function automatic exp_t model(logic [NCH*CW-1:0] fr, bit stb);
      exp_t e;
      bit   used[NCH];
      e = '0;
      for (int c = 0; c < NCH; c++) used[c] = 1'b0;
      if (!stb) return e;
      for (int k = 0; k < NOUT; k++) begin
         int best;
         int bestkey;
         best = -1;
         bestkey = -1;
         for (int c = 0; c < NCH; c++) begin
            int q;
            int key;
            q = int'(fr[c*CW+11 +: 4]);
            if (!used[c] && fr[c*CW+15] && q != 0) begin
               key = q * 64 + c;
               if (key > bestkey) begin bestkey = key; best = c; end
            end
         end
         if (best >= 0) begin
            used[best] = 1'b1;
            e.fr[k*CW +: CW] = fr[best*CW +: CW];
            e.v[k] = 1'b1;
            e.w[best] = 1'b1;
         end
      end
      return e;
   endfunction

   task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) hist.push_back(model(in_frames, in_strobe));
      else hist.push_back('0);
      if (hist.size() > 4) void'(hist.pop_front());
   end

   always @(negedge clk) begin
      if (cmp_en && hist.size() >= 2) begin
         exp_t e;
         e = hist[hist.size()-2];
         check(out_frames == e.fr, "R1 R2 R3 R10 frames", 128'(out_frames), 128'(e.fr));
         check(out_valid == e.v, "R4 R5 valid", 128'(out_valid), 128'(e.v));
         check(led == e.v, "R6 led", 128'(led), 128'(e.v));
         check(winner == e.w, "R7 winner", 128'(winner), 128'(e.w));
      end
   end

   task automatic drive(logic [NCH*CW-1:0] fr, bit stb);
      @(negedge clk);
      in_frames = fr;
      in_strobe = stb;
   endtask

   // strobe one slot, then idle; returns after outputs of that slot settle
   task automatic run_one(logic [NCH*CW-1:0] fr);
      drive(fr, 1'b1);
      drive('0, 1'b0);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [NCH*CW-1:0] v;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(out_valid == 0 && winner == 0 && led == 0 && out_frames == 0, "R9 reset",
            128'({out_valid, winner, led}), 128'(0));
      in_frames = '1;
      in_strobe = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && winner == 0 && out_frames == 0, "R9 reset with strobe", 128'(winner), 128'(0));
      in_frames = '0;
      in_strobe = 1'b0;
      rst_n = 1'b1;
      cmp_en = 1'b1;
      @(negedge clk);

      // single eligible candidate
      v = '0;
      v[4*CW +: CW] = mk(7, 1, 123);
      run_one(v);
      check(out_valid == 3'b001, "R4 one eligible", 128'(out_valid), 128'(1));
      check(out_frames[0 +: CW] == mk(7, 1, 123), "R10 passthrough", 128'(out_frames[0 +: CW]), 128'(mk(7, 1, 123)));
      check(out_frames[CW +: 2*CW] == 0, "R5 empty slots zero", 128'(out_frames[CW +: 2*CW]), 128'(0));
      check(led == 3'b001, "R6 one led", 128'(led), 128'(1));
      check(winner == 18'h00010, "R7 winner ch4", 128'(winner), 128'(18'h10));

      // ineligible: flag clear with top quality, flag set with zero quality
      v = '0;
      v[3*CW +: CW] = mk(15, 0, 1);
      v[5*CW +: CW] = mk(0, 1, 2);
      v[6*CW +: CW] = mk(2, 1, 3);
      v[8*CW +: CW] = mk(9, 1, 4);
      run_one(v);
      check(winner == 18'h00140, "R1 ineligible excluded", 128'(winner), 128'(18'h140));
      check(out_valid == 3'b011, "R4 two eligible", 128'(out_valid), 128'(3));
      check(out_frames[0 +: CW] == mk(9, 1, 4), "R2 best first", 128'(out_frames[0 +: CW]), 128'(mk(9, 1, 4)));

      // all eighteen tied
      v = '0;
      for (int c = 0; c < NCH; c++) v[c*CW +: CW] = mk(5, 1, c);
      run_one(v);
      check(winner == 18'h38000, "R3 tie to high index", 128'(winner), 128'(18'h38000));
      check(out_frames[0 +: CW] == mk(5, 1, 17), "R3 slot0 is ch17", 128'(out_frames[0 +: CW]), 128'(mk(5, 1, 17)));
      check(out_frames[2*CW +: CW] == mk(5, 1, 15), "R3 slot2 is ch15", 128'(out_frames[2*CW +: CW]), 128'(mk(5, 1, 15)));

      // distinct qualities, low channel best
      v = '0;
      for (int c = 0; c < NCH; c++) v[c*CW +: CW] = mk((c < 15) ? 15 - c : 1, 1, c + 40);
      run_one(v);
      check(winner == 18'h00007, "R2 ranking by quality", 128'(winner), 128'(7));
      check(out_frames[CW +: CW] == mk(14, 1, 41), "R2 second slot", 128'(out_frames[CW +: CW]), 128'(mk(14, 1, 41)));

      // live, zero, live back to back
      drive(v, 1'b1);
      drive('0, 1'b1);
      drive(v, 1'b1);
      drive('0, 1'b0);
      check(out_valid == 3'b000 && winner == 0, "R8 zero slot empty", 128'(winner), 128'(0));
      @(negedge clk);
      check(winner == 18'h00007, "R8 slot after zero slot", 128'(winner), 128'(7));

      // random traffic with narrow qualities for ties
      for (int n = 0; n < 3000; n++) begin
         logic [NCH*CW-1:0] r;
         for (int c = 0; c < NCH; c++) begin
            int q;
            q = (n % 2 == 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 15));
            r[c*CW +: CW] = mk(q, 1'($urandom_range(0, 1)), int'($urandom));
         end
         drive(r, ($urandom_range(0, 7) != 0));
      end
      drive('0, 1'b0);
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule